// File: doc/BRIEF.md
# Fixed-Vector Interrupt Unit

This block decides when the processor's instruction sequencer must enter an interrupt routine, and where that routine starts. Requests come from two places. The executing program can raise a software interrupt with a 3-bit number. Two external request lines can also raise an interrupt, and these are sampled only at instruction boundaries. An accepted request produces a one-cycle take strobe together with a 24-bit start address. On that strobe the sequencer saves its program counter and jumps to the address.

Each interrupt number owns a 256-word region of the address space. Number n starts at `n * 256` (hex 000n00) and ends at hex 000nFF. The two external lines reuse numbers 0 and 1. For that reason a software request for 0 or 1 is refused and reported on a fault output. The unit also holds the interrupt-enable flag, which the sequencer sets and clears with dedicated strobes. Taking an external interrupt clears the flag automatically.

The controller is a three-state machine:
- **IDLE** waits for a request. In IDLE it can go to **TAKE**, when a valid software request or an enabled external request at a boundary is accepted. It can also go to **FAULT**, when a software request names a reserved number.
- **TAKE** drives the strobe and the address for one cycle, then returns to IDLE.
- **FAULT** drives the fault pulse for one cycle, then returns to IDLE.

Requests that arrive while the machine is in TAKE or FAULT are dropped.

Top module: `irq_vector_unit`

## Requirements
- R1: A software request with a number from 2 to 7 is accepted whatever the enable flag holds. `take_irq` is high for exactly the one cycle that follows the request edge.
- R2: While `take_irq` is high, `vec_addr` equals the accepted number times 256 (hex 000n00). While `take_irq` is low, `vec_addr` is zero.
- R3: A software request with number 0 or 1 never raises `take_irq`. It raises `swi_fault` for the one cycle that follows the request edge.
- R4: `set_ie` sets `ie_flag` and `clr_ie` clears it, each taking effect at the next edge. If both strobes are high on the same edge, clear wins. The flag is 0 after reset.
- R5: When `ie_flag` is 1 and `instr_edge` is 1, `hw_req_a` is taken with number 0 (address hex 000000). On that same edge `ie_flag` is cleared.
- R6: Under the same conditions, `hw_req_b` is taken with number 1 (address hex 000100).
- R7: When both hardware lines request on the same edge, `hw_req_a` wins.
- R8: Hardware requests have no effect while `ie_flag` is 0 or `instr_edge` is 0.
- R9: A software request on the same edge as a hardware request is served first. The hardware request is not taken on that edge.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swi_req | input | 1 | Software interrupt strobe |
| swi_num | input | 3 | Software interrupt number |
| set_ie | input | 1 | Set the enable flag |
| clr_ie | input | 1 | Clear the enable flag |
| hw_req_a | input | 1 | External request, higher priority, number 0 |
| hw_req_b | input | 1 | External request, lower priority, number 1 |
| instr_edge | input | 1 | High at an instruction boundary |
| take_irq | output | 1 | One-cycle take strobe |
| vec_addr | output | 24 | Routine start address, valid with take_irq |
| ie_flag | output | 1 | Interrupt-enable flag |
| swi_fault | output | 1 | One-cycle pulse when a reserved software number is requested |

## Verification
Software requests are applied for every number from 2 to 7 with the flag clear. This separates correct address scaling from a swapped or shifted number field. Requests for 0 and 1 show that reserved numbers take the fault path rather than the take path.

The external lines are driven four ways: alone, together, with the flag clear, and off an instruction boundary. These patterns separate priority, gating and the automatic clearing of the flag. Finally, a software request is applied on the same edge as an external request, which exposes the source ordering.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TAKE  = 2'd1,
        ST_FAULT = 2'd2
    } irqv_state_e;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_SW   = 2'd1,
        REQ_HW   = 2'd2,
        REQ_BAD  = 2'd3
    } irqv_req_e;
endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int NUM_W = 3,
    parameter int RSV_N = 2
) (
    input  logic             arb_en,
    input  logic             swi_req,
    input  logic [NUM_W-1:0] swi_num,
    input  logic             hw_req_a,
    input  logic             hw_req_b,
    input  logic             instr_edge,
    input  logic             ie,
    output irqv_req_e        kind,
    output logic [NUM_W-1:0] num
);
    localparam logic [NUM_W-1:0] NUM_A = NUM_W'(0);
    localparam logic [NUM_W-1:0] NUM_B = NUM_W'(1);

    logic hw_open;
    assign hw_open = instr_edge && ie;

    always_comb begin
        kind = REQ_NONE;
        num  = '0;
        if (arb_en) begin
            if (swi_req) begin
                num  = swi_num;
                kind = (int'(swi_num) < RSV_N) ? REQ_BAD : REQ_SW;
            end else if (hw_open && hw_req_a) begin
                kind = REQ_HW;
                num  = NUM_A;
            end else if (hw_open && hw_req_b) begin
                kind = REQ_HW;
                num  = NUM_B;
            end
        end
    end
endmodule

// File: rtl/irqv_ie_flag.sv
module irqv_ie_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ie,
    input  logic clr_ie,
    input  logic hw_taken,
    output logic ie
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ie <= 1'b0;
        else if (hw_taken || clr_ie)
            ie <= 1'b0;
        else if (set_ie)
            ie <= 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ie |=> !ie); // R4
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ie && !clr_ie && !hw_taken) |=> ie); // R4
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int NUM_W  = 3,
    parameter int SLOT_W = 8,
    parameter int ADDR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swi_req,
    input  logic [NUM_W-1:0] swi_num,
    input  logic             set_ie,
    input  logic             clr_ie,
    input  logic             hw_req_a,
    input  logic             hw_req_b,
    input  logic             instr_edge,
    output logic             take_irq,
    output logic [ADDR_W-1:0] vec_addr,
    output logic             ie_flag,
    output logic             swi_fault
);
    localparam int RSV_N = 2;

    irqv_state_e      state_q, state_d;
    logic [NUM_W-1:0] num_q;
    irqv_req_e        kind;
    logic [NUM_W-1:0] arb_num;
    logic             hw_grant;

    irqv_arbiter #(.NUM_W(NUM_W), .RSV_N(RSV_N)) u_arb (
        .arb_en     (state_q == ST_IDLE),
        .swi_req    (swi_req),
        .swi_num    (swi_num),
        .hw_req_a   (hw_req_a),
        .hw_req_b   (hw_req_b),
        .instr_edge (instr_edge),
        .ie         (ie_flag),
        .kind       (kind),
        .num        (arb_num)
    );

    assign hw_grant = (kind == REQ_HW);

    irqv_ie_flag u_ie (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ie   (set_ie),
        .clr_ie   (clr_ie),
        .hw_taken (hw_grant),
        .ie       (ie_flag)
    );

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (kind == REQ_SW || kind == REQ_HW) state_d = ST_TAKE;
                else if (kind == REQ_BAD)             state_d = ST_FAULT;
                else                                  state_d = ST_IDLE;
            end
            ST_TAKE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            num_q   <= '0;
        end else begin
            state_q <= state_d;
            if (kind == REQ_SW || kind == REQ_HW)
                num_q <= arb_num;
        end
    end

    always_comb begin
        take_irq  = (state_q == ST_TAKE);
        swi_fault = (state_q == ST_FAULT);
        vec_addr  = take_irq ? (ADDR_W'(num_q) << SLOT_W) : '0;
    end

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq); // R1
    AST_NO_TAKE_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_irq && swi_fault)); // R3
    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> (vec_addr == '0)); // R2
    AST_VEC_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (vec_addr[SLOT_W-1:0] == '0)); // R2
    AST_HW_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        hw_grant |=> (!ie_flag && take_irq)); // R5
    AST_HW_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        hw_grant |-> (instr_edge && !swi_req)); // R8
endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swi_req = 1'b0;
    logic [2:0]  swi_num = '0;
    logic        set_ie = 1'b0;
    logic        clr_ie = 1'b0;
    logic        hw_req_a = 1'b0;
    logic        hw_req_b = 1'b0;
    logic        instr_edge = 1'b0;
    logic        take_irq;
    logic [23:0] vec_addr;
    logic        ie_flag;
    logic        swi_fault;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_unit u_irq_vector_unit (
        .clk(clk), .rst_n(rst_n), .swi_req(swi_req), .swi_num(swi_num),
        .set_ie(set_ie), .clr_ie(clr_ie), .hw_req_a(hw_req_a),
        .hw_req_b(hw_req_b), .instr_edge(instr_edge), .take_irq(take_irq),
        .vec_addr(vec_addr), .ie_flag(ie_flag), .swi_fault(swi_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic release_all();
        swi_req = 0; set_ie = 0; clr_ie = 0;
        hw_req_a = 0; hw_req_b = 0; instr_edge = 0;
    endtask

    task automatic set_flag(input logic v);
        @(negedge clk);
        set_ie = v; clr_ie = !v;
        @(negedge clk);
        release_all();
        chk("R4 flag write", ie_flag, v);
    endtask

    task automatic t_reset();
        chk("R10 take", take_irq, 0);
        chk("R10 vec", vec_addr, 0);
        chk("R10 ie", ie_flag, 0);
        chk("R10 fault", swi_fault, 0);
    endtask

    task automatic t_swi_all();
        for (int n = 2; n < 8; n++) begin
            @(negedge clk);
            swi_req = 1; swi_num = 3'(n);
            @(negedge clk);
            release_all();
            chk("R1 take", take_irq, 1);
            chk("R2 vector", vec_addr, 32'(n) << 8);
            chk("R3 no fault on valid", swi_fault, 0);
            @(negedge clk);
            chk("R1 single cycle", take_irq, 0);
            chk("R2 vec zero after", vec_addr, 0);
        end
    endtask

    task automatic t_swi_reserved();
        for (int n = 0; n < 2; n++) begin
            @(negedge clk);
            swi_req = 1; swi_num = 3'(n);
            @(negedge clk);
            release_all();
            chk("R3 no take", take_irq, 0);
            chk("R3 fault", swi_fault, 1);
            @(negedge clk);
            chk("R3 fault one cycle", swi_fault, 0);
            chk("R3 still no take", take_irq, 0);
        end
    endtask

    task automatic t_ie_strobes();
        set_flag(1);
        set_flag(0);
        @(negedge clk);
        set_ie = 1; clr_ie = 1;
        @(negedge clk);
        release_all();
        chk("R4 clear wins", ie_flag, 0);
    endtask

    task automatic t_hw(input logic a, input logic b, input logic [23:0] exp_vec, input string req);
        set_flag(1);
        @(negedge clk);
        hw_req_a = a; hw_req_b = b; instr_edge = 1;
        @(negedge clk);
        release_all();
        chk({req, " take"}, take_irq, 1);
        chk({req, " vector"}, vec_addr, exp_vec);
        chk("R5 ie auto clear", ie_flag, 0);
        @(negedge clk);
        chk({req, " single cycle"}, take_irq, 0);
    endtask

    task automatic t_hw_blocked();
        set_flag(0);
        @(negedge clk);
        hw_req_a = 1; hw_req_b = 1; instr_edge = 1;
        @(negedge clk);
        release_all();
        chk("R8 ie clear blocks", take_irq, 0);
        set_flag(1);
        @(negedge clk);
        hw_req_a = 1; hw_req_b = 1; instr_edge = 0;
        @(negedge clk);
        release_all();
        chk("R8 no boundary blocks", take_irq, 0);
        chk("R8 ie kept", ie_flag, 1);
    endtask

    task automatic t_sw_first();
        set_flag(1);
        @(negedge clk);
        swi_req = 1; swi_num = 3'd5; hw_req_a = 1; instr_edge = 1;
        @(negedge clk);
        release_all();
        chk("R9 take", take_irq, 1);
        chk("R9 software vector", vec_addr, 24'h000500);
        chk("R9 ie untouched", ie_flag, 1);
        @(negedge clk);
        chk("R9 idle after", take_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_swi_all();
        t_swi_reserved();
        t_ie_strobes();
        t_hw(1, 0, 24'h000000, "R5");
        t_hw(0, 1, 24'h000100, "R6");
        t_hw(1, 1, 24'h000000, "R7");
        t_hw_blocked();
        t_sw_first();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule